// File: doc/BRIEF.md
# Write-Through Random-Replacement Cache

This block is a unified 4 KB cache that sits between a processor and a slow memory port. It is organised as four sets. Each set holds 64 fully associative lines, and each line holds four 32-bit words. Address bits [5:4] pick the set, so sixteen consecutive words spread over all four sets. The line tag is address bits [31:6]. A read that hits completes in the same cycle it is presented, whatever its address or access pattern. A read miss invalidates a victim line in the selected set. It then fetches the whole 16-byte-aligned line, one word per memory beat, in ascending word order. The processor is released in the beat that delivers the word it asked for.

The processor holds `cpu_req` with its address, direction and data until it sees `cpu_wait` low at a clock edge; the access completes at that edge. The memory port holds `mem_req`, `mem_addr` and `mem_wdata` until `mem_ack` is high at an edge, and every acknowledged beat moves one word. Writes always pass straight through to memory. A write also updates the cached copy when the word is present, and a write miss allocates nothing.

Control is a two-state machine. In `S_IDLE` the block serves hits and passes writes through. The transition `start_fill` (a read miss while in `S_IDLE`) moves it to `S_FILL`, where it fetches the four beats of the line. The transition `fill_done` (acknowledgement of the last beat) returns it to `S_IDLE`. The victim way comes from a free-running pseudo-random sequence.

Top module: `wt_rand_cache`

## Requirements
- R1: After reset every line is invalid, `mem_req` is low, and `cpu_wait` is low whenever `cpu_req` is low.
- R2: In `S_IDLE`, a read whose tag is valid in its set sees `cpu_wait` low in its first cycle, with the cached word on `cpu_rdata`.
- R3: The set index is address bits [5:4] and the tag is bits [31:6]. A fill replaces one line of its own set only, and lines in other sets stay resident.
- R4: A read miss issues four read beats to addresses base, base+4, base+8, base+12, where base is the miss address with bits [3:0] cleared. Each address is held until `mem_ack`.
- R5: A read miss first spends one lookup cycle and then drops `cpu_wait` in the cycle its own word's beat is acknowledged, with `cpu_rdata` equal to `mem_rdata`.
- R6: During `S_FILL`, after the missing word has been delivered, a read of a word of the filling line that is already loaded completes in one cycle. Any other access waits until the fill has finished.
- R7: Every write drives `mem_req` and `mem_we` with the processor's address and data and keeps `cpu_wait` high until `mem_ack`. If the word is cached, its copy takes the new data.
- R8: A write miss leaves the cache unchanged, so a later read of that address misses and returns the written data from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read or fetch |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when `cpu_wait` is low |
| cpu_wait | output | 1 | Stall: the access does not complete this cycle |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | 32 | Memory beat byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Beat accepted / read data valid this cycle |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bench times every access in cycles.

- **Critical-word timing.** Misses target each word position of a line. A fill that released the processor only at the end of the line, or one beat late, gives the wrong latency.
- **Reads during a fill.** The bench reads words of the filling line that are already loaded and words that are not yet loaded. A design that served unloaded words would return stale data, and one that stalled loaded words would be slow.
- **Writes.** Writes that hit are followed by one-cycle reads that must show the new data. A write miss is followed by a read that must miss, which exposes write allocation and dropped write-through.
- **Set isolation and reset.** A line in another set is read after a fill and must still hit. A reset in the middle of the run must turn known hits back into misses.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_FILL = 1'b1
    } fill_state_e;

endpackage

// File: rtl/rc_lfsr.sv
module rc_lfsr #(
    parameter int          W     = 7,
    parameter int          OUT_W = 6,
    parameter logic [W-1:0] TAPS = 7'h60,
    parameter logic [W-1:0] SEED = 7'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] q
);

    logic [W-1:0] st;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SEED;
        else        st <= {st[W-2:0], ^(st & TAPS)};
    end

    assign q = st[OUT_W-1:0];

endmodule

// File: rtl/rc_tag_store.sv
module rc_tag_store #(
    parameter int SETS  = 4,
    parameter int WAYS  = 64,
    parameter int TAG_W = 26,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_valid
);

    logic [TAG_W-1:0] tags  [SETS][WAYS];
    logic [WAYS-1:0]  valid [SETS];
    logic [WAYS-1:0]  match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid[s] <= '0;
        end else if (wr_en) begin
            valid[wr_set][wr_way] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tags[wr_set][wr_way] <= wr_tag;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[lk_set][w] && (tags[lk_set][w] == lk_tag);
    end

    always_comb begin
        lk_hit = |match;
        lk_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) lk_way = lk_way | WAY_W'(w);
        end
    end

endmodule

// File: rtl/rc_data_ram.sv
module rc_data_ram #(
    parameter int DW    = 32,
    parameter int DEPTH = 1024,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] ram [DEPTH];

    always_ff @(posedge clk) begin
        if (we) ram[waddr] <= wdata;
    end

    assign rdata = ram[raddr];

endmodule

// File: rtl/wt_rand_cache.sv
module wt_rand_cache
    import wt_cache_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter int          SETS      = 4,
    parameter int          WAYS      = 64,
    parameter int          WORDS     = 4,
    parameter int          LFSR_W    = 7,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 7'h60,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 7'h5A
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_wait,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    localparam int BYTE_W   = $clog2(DW / 8);
    localparam int OFF_W    = $clog2(WORDS);
    localparam int SET_W    = $clog2(SETS);
    localparam int WAY_W    = $clog2(WAYS);
    localparam int LINE_LSB = BYTE_W + OFF_W;
    localparam int TAG_LSB  = LINE_LSB + SET_W;
    localparam int TAG_W    = AW - TAG_LSB;
    localparam int LINE_W   = AW - LINE_LSB;
    localparam int IDX_W    = SET_W + WAY_W + OFF_W;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

    // processor address fields
    logic [OFF_W-1:0]  c_word;
    logic [SET_W-1:0]  c_set;
    logic [TAG_W-1:0]  c_tag;
    logic [LINE_W-1:0] c_line;

    assign c_word = cpu_addr[LINE_LSB-1:BYTE_W];
    assign c_set  = cpu_addr[TAG_LSB-1:LINE_LSB];
    assign c_tag  = cpu_addr[AW-1:TAG_LSB];
    assign c_line = cpu_addr[AW-1:LINE_LSB];

    // fill context
    fill_state_e       state, state_nx;
    logic [LINE_W-1:0] f_line;
    logic [WAY_W-1:0]  f_way;
    logic [OFF_W-1:0]  f_crit;
    logic [OFF_W-1:0]  f_beat;
    logic              f_done;
    logic [WORDS-1:0]  f_loaded;
    logic [SET_W-1:0]  f_set;
    logic [TAG_W-1:0]  f_tag;

    assign f_set = f_line[SET_W-1:0];
    assign f_tag = f_line[LINE_W-1:SET_W];

    // sub-block wiring
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim;
    logic             tag_we;
    logic [SET_W-1:0] tag_set;
    logic [WAY_W-1:0] tag_way;
    logic             tag_valid;
    logic             ram_we;
    logic [IDX_W-1:0] ram_widx;
    logic [DW-1:0]    ram_wdata;
    logic [IDX_W-1:0] ram_ridx;
    logic [DW-1:0]    ram_rdata;

    logic start_fill, beat_ack, fill_done;

    assign start_fill = (state == S_IDLE) && cpu_req && !cpu_we && !hit;
    assign beat_ack   = (state == S_FILL) && mem_ack;
    assign fill_done  = beat_ack && (f_beat == LAST_BEAT);

    rc_lfsr #(
        .W(LFSR_W), .OUT_W(WAY_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)
    ) i_lfsr (
        .clk(clk), .rst_n(rst_n), .q(victim)
    );

    rc_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)
    ) i_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_set(c_set), .lk_tag(c_tag), .lk_hit(hit), .lk_way(hit_way),
        .wr_en(tag_we), .wr_set(tag_set), .wr_way(tag_way),
        .wr_tag(f_tag), .wr_valid(tag_valid)
    );

    rc_data_ram #(
        .DW(DW), .DEPTH(SETS * WAYS * WORDS)
    ) i_ram (
        .clk(clk), .we(ram_we), .waddr(ram_widx), .wdata(ram_wdata),
        .raddr(ram_ridx), .rdata(ram_rdata)
    );

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start_fill) state_nx = S_FILL;
            S_FILL: if (fill_done)  state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // fill context register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_line   <= '0;
            f_way    <= '0;
            f_crit   <= '0;
            f_beat   <= '0;
            f_done   <= 1'b0;
            f_loaded <= '0;
        end else if (start_fill) begin
            f_line   <= c_line;
            f_way    <= victim;
            f_crit   <= c_word;
            f_beat   <= '0;
            f_done   <= 1'b0;
            f_loaded <= '0;
        end else if (beat_ack) begin
            f_beat           <= f_beat + 1'b1;
            f_loaded[f_beat] <= 1'b1;
            if (f_beat == f_crit) f_done <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        cpu_wait  = 1'b0;
        cpu_rdata = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ram_ridx  = {c_set, hit_way, c_word};
        ram_we    = 1'b0;
        ram_widx  = {f_set, f_way, f_beat};
        ram_wdata = mem_rdata;
        tag_we    = 1'b0;
        tag_set   = f_set;
        tag_way   = f_way;
        tag_valid = 1'b1;
        unique case (state)
            S_IDLE: begin
                if (cpu_req && cpu_we) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = cpu_addr;
                    mem_wdata = cpu_wdata;
                    cpu_wait  = !mem_ack;
                    if (mem_ack && hit) begin
                        ram_we    = 1'b1;
                        ram_widx  = {c_set, hit_way, c_word};
                        ram_wdata = cpu_wdata;
                    end
                end else if (cpu_req && hit) begin
                    cpu_rdata = ram_rdata;
                end else if (cpu_req) begin
                    cpu_wait  = 1'b1;
                    tag_we    = 1'b1;
                    tag_set   = c_set;
                    tag_way   = victim;
                    tag_valid = 1'b0;
                end
            end
            S_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {f_line, f_beat, {BYTE_W{1'b0}}};
                ram_we   = mem_ack;
                tag_we   = fill_done;
                if (cpu_req) begin
                    if (!f_done) begin
                        cpu_wait  = !(mem_ack && (f_beat == f_crit));
                        cpu_rdata = mem_rdata;
                    end else if (!cpu_we && (c_line == f_line) && f_loaded[c_word]) begin
                        ram_ridx  = {f_set, f_way, c_word};
                        cpu_rdata = ram_rdata;
                    end else begin
                        cpu_wait = 1'b1;
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/wt_rand_cache_chk.sv
module wt_rand_cache_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic [AW-1:0] cpu_addr,
    input logic [DW-1:0] cpu_wdata,
    input logic [DW-1:0] cpu_rdata,
    input logic          cpu_wait,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack,
    input logic [DW-1:0] mem_rdata
);

    assert_no_idle_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> !cpu_wait);

    assert_fill_addr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !mem_ack) |=> $stable(mem_addr));

    assert_fill_addr_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && (mem_addr[3:2] != 2'b11))
            |=> (mem_req && !mem_we && (mem_addr == $past(mem_addr) + 4)));

    assert_crit_word_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !cpu_wait && mem_req && !mem_we && mem_ack
            && (mem_addr == cpu_addr)) |-> (cpu_rdata == mem_rdata));

    assert_write_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !cpu_wait) |->
            (mem_req && mem_we && mem_ack && (mem_addr == cpu_addr)
                && (mem_wdata == cpu_wdata)));

endmodule

bind wt_rand_cache wt_rand_cache_chk #(.AW(AW), .DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
);

// File: tb/test_wt_rand_cache.sv
`timescale 1ns/1ps
module test_wt_rand_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_wait;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        ack_r;

    always #4 clk = ~clk;

    wt_rand_cache i_wt_rand_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(ack_r), .mem_rdata(mem_rdata)
    );

    // memory model: acknowledges every second cycle of a held request
    bit          wr_flag [1024];
    bit   [31:0] wr_val  [1024];
    logic [31:0] ack_log [64];
    int          log_n = 0;

    assign mem_rdata = wr_flag[mem_addr[11:2]] ? wr_val[mem_addr[11:2]]
                                               : (32'hC0DE_0000 | 32'(mem_addr[11:2]));

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_r <= 1'b0;
        end else begin
            ack_r <= mem_req && !ack_r;
            if (mem_req && ack_r && mem_we) begin
                wr_flag[mem_addr[11:2]] <= 1'b1;
                wr_val[mem_addr[11:2]]  <= mem_wdata;
            end
            if (mem_req && ack_r && !mem_we) begin
                ack_log[log_n[5:0]] <= mem_addr;
                log_n <= log_n + 1;
            end
        end
    end

    int n_total = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output int cyc);
        bit done;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = wr; cpu_addr = a; cpu_wdata = wd;
        cyc = 0; done = 1'b0; rd = '0;
        while (!done) begin
            #1;
            cyc++;
            if (!cpu_wait) begin
                rd = cpu_rdata;
                done = 1'b1;
            end else begin
                @(negedge clk);
            end
        end
        @(posedge clk);
    endtask

    task automatic go_idle(input int n);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        repeat (n) @(posedge clk);
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] edata;
        logic [7:0]  ecyc;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h000, 32'h0,         32'hC0DE_0000, 8'd3, 8'd5}, // R5 miss, word 0
        '{1'b0, 32'h004, 32'h0,         32'hC0DE_0001, 8'd3, 8'd6}, // R6 word not yet loaded
        '{1'b0, 32'h000, 32'h0,         32'hC0DE_0000, 8'd1, 8'd6}, // R6 loaded word in fill
        '{1'b0, 32'h00C, 32'h0,         32'hC0DE_0003, 8'd3, 8'd6}, // R6 waits for fill end
        '{1'b1, 32'h008, 32'h1111_2222, 32'h0,         8'd2, 8'd7}, // R7 write hit
        '{1'b0, 32'h008, 32'h0,         32'h1111_2222, 8'd1, 8'd7}, // R7 cached copy updated
        '{1'b1, 32'h018, 32'h3333_4444, 32'h0,         8'd2, 8'd8}, // R8 write miss
        '{1'b0, 32'h018, 32'h0,         32'h3333_4444, 8'd7, 8'd8}, // R8 no allocate, word 2
        '{1'b0, 32'h040, 32'h0,         32'hC0DE_0010, 8'd5, 8'd6}, // R6 other line during fill
        '{1'b0, 32'h01C, 32'h0,         32'hC0DE_0007, 8'd7, 8'd3}, // R3 set 1 survives set 0 fill
        '{1'b1, 32'h044, 32'h5555_6666, 32'h0,         8'd2, 8'd7}, // R7
        '{1'b0, 32'h044, 32'h0,         32'h5555_6666, 8'd1, 8'd2}, // R2 hit
        '{1'b0, 32'h080, 32'h0,         32'hC0DE_0020, 8'd3, 8'd5}, // R5
        '{1'b1, 32'h0A0, 32'h7777_8888, 32'h0,         8'd8, 8'd6}, // R6 write stalls during fill
        '{1'b0, 32'h0A0, 32'h0,         32'h7777_8888, 8'd3, 8'd8}, // R8 miss sees written data
        '{1'b0, 32'h0AC, 32'h0,         32'hC0DE_002B, 8'd7, 8'd6}, // R6
        '{1'b0, 32'h0FC, 32'h0,         32'hC0DE_003F, 8'd9, 8'd5}, // R5 last word critical
        '{1'b0, 32'h0F0, 32'h0,         32'hC0DE_003C, 8'd1, 8'd2}  // R2 hit after fill
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        int          cyc;
        int          start;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(cpu_wait == 1'b0, "R1 wait idle", 32'(cpu_wait), 32'h0);
        check(mem_req == 1'b0, "R1 mem_req idle", 32'(mem_req), 32'h0);

        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i].wr, VEC[i].addr, VEC[i].wdata, rd, cyc);
            check(cyc == int'(VEC[i].ecyc), $sformatf("R%0d cycles op %0d", VEC[i].rq, i),
                  32'(cyc), 32'(VEC[i].ecyc));
            if (!VEC[i].wr)
                check(rd == VEC[i].edata, $sformatf("R%0d data op %0d", VEC[i].rq, i),
                      rd, VEC[i].edata);
        end

        // R1: reset mid-run invalidates every line
        go_idle(2);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(cpu_wait == 1'b0 && mem_req == 1'b0, "R1 after second reset",
              {30'b0, cpu_wait, mem_req}, 32'h0);
        start = log_n;
        run_op(1'b0, 32'h0F8, 32'h0, rd, cyc);
        check(cyc == 7, "R1 cached line lost at reset (cycles)", 32'(cyc), 32'd7);
        check(rd == 32'hC0DE_003E, "R5 data word 2", rd, 32'hC0DE_003E);

        // R4: fill beat order
        go_idle(6);
        check(log_n - start == 4, "R4 beat count", 32'(log_n - start), 32'd4);
        for (int b = 0; b < 4; b++) begin
            check(ack_log[(start + b) % 64] == 32'h0F0 + 32'(4 * b), "R4 beat address",
                  ack_log[(start + b) % 64], 32'h0F0 + 32'(4 * b));
        end

        run_op(1'b0, 32'h0F0, 32'h0, rd, cyc);
        check(cyc == 1, "R2 hit cycles", 32'(cyc), 32'd1);
        check(rd == 32'hC0DE_003C, "R2 hit data", rd, 32'hC0DE_003C);

        go_idle(2);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule